// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block turns parallel characters into a single serial line with start/stop framing. Each character has one start bit at space (0). Then come 5 to 8 data bits, least significant first. An optional parity bit follows. The frame ends with a stop period at mark (1) that lasts one, one-and-a-half or two bit times. The line rests at mark between characters.

Bit timing comes from a clock-enable input, `clk_en`. A clock-factor setting chooses how many enable pulses make up one bit time. The x1 setting sends one bit per pulse, which suits isochronous links where the bit clock travels with the data. The x16, x32 and x64 settings suit oversampled links.

A host offers characters on a valid/ready load port. The framing inputs are captured along with each character. During the stop period of the frame on the line, one further character can be accepted. That character then starts the moment the stop period ends, so a stream of characters leaves no idle bits between frames.

Top module: `async_char_tx`

## Requirements
- R1: After reset, and whenever no frame is being sent, `tx_line` is 1. Every frame begins with a start bit of 0 that lasts one bit time.
- R2: `cfg_len_sel` selects the data length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Data is taken right-justified from `load_data` and sent least significant bit first. Bits above the selected length have no effect on the line.
- R3: With `cfg_par_en` = 1, one parity bit is sent after the last data bit. `cfg_par_even` = 1 makes the data bits plus the parity bit hold an even count of ones. `cfg_par_even` = 0 makes that count odd. With `cfg_par_en` = 0, no parity bit is sent.
- R4: `cfg_stop_sel` selects the stop period at mark: 01 = one bit time, 10 = one and a half bit times, 11 = two bit times.
- R5: `cfg_factor` selects the bit time in `clk_en` pulses: 00 = 1, 01 = 16, 10 = 32, 11 = 64. The line level changes only on a clock edge that follows a counted enable pulse, or when a frame starts.
- R6: When `cfg_factor` is 00 (x1) and `cfg_stop_sel` is 10, the stop period lasts two bit times.
- R7: While `cfg_stop_sel` is 00, `load_ready` is 0. Any character offered on `load_valid` is not accepted, and the line stays at mark.
- R8: The framing inputs are captured on the edge that accepts a character. Changing them during that frame has no effect on that frame.
- R9: `load_ready` is 1 only while the line is idle, or during the stop period of a frame when no character is already waiting. A character accepted during the stop period starts with no mark bit between frames.
- R10: A character is accepted on a rising clock edge where `load_valid` and `load_ready` are both 1. Accepted in idle, it drives the start bit from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Bit-timing enable pulse |
| load_valid | input | 1 | A character is offered |
| load_ready | output | 1 | A character can be accepted |
| load_data | input | 8 | Character, right-justified |
| cfg_len_sel | input | 2 | Data length select |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop_sel | input | 2 | Stop period select, 00 = disabled |
| cfg_factor | input | 2 | Clock factor select |
| tx_line | output | 1 | Serial output, idle at 1 |

## Verification
The embedded assertions check the following on every cycle:
- Captured framing stays frozen between loads.
- A waiting character is neither lost nor changed until it starts.
- `load_ready` appears only in the idle or stop phase.
- The line moves only after a counted enable pulse or a frame start.
- The pulse counter never passes the bit time.

Only the bench's scenarios show the following:
- The serial content is correct: data order, masking of unused bits, parity value, and the exact number of enable pulses per start, data and stop bit under each factor.
- The x1 one-and-a-half-stop substitution.
- The zero-gap hand-over between back-to-back frames.
- The disabled stop setting.

// File: rtl/atx_pkg.sv
`timescale 1ns/1ps
package atx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_START  = 3'd1,
      ST_DATA   = 3'd2,
      ST_PARITY = 3'd3,
      ST_STOP   = 3'd4
   } atx_state_e;

   typedef enum logic [1:0] {
      FAC_X1  = 2'b00,
      FAC_X16 = 2'b01,
      FAC_X32 = 2'b10,
      FAC_X64 = 2'b11
   } atx_factor_e;

   typedef enum logic [1:0] {
      STOP_OFF  = 2'b00,
      STOP_ONE  = 2'b01,
      STOP_HALF = 2'b10,
      STOP_TWO  = 2'b11
   } atx_stop_e;

   typedef struct packed {
      logic [1:0]  len_sel;
      logic        par_en;
      logic        par_even;
      atx_stop_e   stop;
      atx_factor_e factor;
   } atx_cfg_t;

endpackage

// File: rtl/atx_bit_timer.sv
`timescale 1ns/1ps
module atx_bit_timer
   import atx_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int LOG_A = 4,
   parameter int LOG_B = 5,
   parameter int LOG_C = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clk_en,
   input  logic        run,
   input  logic        in_stop,
   input  atx_factor_e factor,
   input  atx_stop_e   stop_sel,
   output logic        bit_done
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (LOG_A < 1 || LOG_B <= LOG_A || LOG_C <= LOG_B || CNT_W < LOG_C + 2) begin : g_bad_cfg
      $error("atx_bit_timer: factor exponents must rise and fit the counter");
   end

   logic [CNT_W-1:0] unit_tbl [4];
   logic [CNT_W-1:0] unit_len;
   logic [CNT_W-1:0] target;
   logic [CNT_W-1:0] cnt;

   for (genvar g = 0; g < 4; g++) begin : g_unit
      localparam int SH = (g == 0) ? 0 : (g == 1) ? LOG_A : (g == 2) ? LOG_B : LOG_C;
      assign unit_tbl[g] = ONE << SH;
   end

   assign unit_len = unit_tbl[factor];

   always_comb begin
      target = unit_len;
      if (in_stop) begin
         case (stop_sel)
            STOP_TWO:  target = unit_len << 1;
            STOP_HALF: target = (factor == FAC_X1) ? (unit_len << 1)
                                                   : (unit_len + (unit_len >> 1));
            default:   target = unit_len;
         endcase
      end
   end

   assign bit_done = clk_en && run && (cnt == target - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || bit_done) begin
         cnt <= '0;
      end else if (clk_en) begin
         cnt <= cnt + ONE;
      end
   end

   assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < target));

endmodule

// File: rtl/atx_parity.sv
`timescale 1ns/1ps
module atx_parity #(
   parameter int DATA_W   = 8,
   parameter int MIN_BITS = 5,
   parameter int SEL_W    = 2
) (
   input  logic [DATA_W-1:0] data,
   input  logic [SEL_W-1:0]  len_sel,
   input  logic              even,
   output logic              par_bit
);

   logic [DATA_W-1:0] keep;

   for (genvar i = 0; i < DATA_W; i++) begin : g_keep
      if (i < MIN_BITS) begin : g_always
         assign keep[i] = 1'b1;
      end else begin : g_sel
         assign keep[i] = (int'(len_sel) + MIN_BITS) > i;
      end
   end

   assign par_bit = (^(data & keep)) ^ ~even;

endmodule

// File: rtl/atx_frame_ctrl.sv
`timescale 1ns/1ps
module atx_frame_ctrl
   import atx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MIN_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_v,
   input  logic [DATA_W-1:0] src_data,
   input  atx_cfg_t          src_cfg,
   input  logic              bit_done,
   output logic              take,
   output atx_state_e        state_o,
   output atx_cfg_t          cfg_o,
   output logic              run_o,
   output logic              in_stop_o,
   output logic              line_o
);

   localparam int BL_W = $clog2(DATA_W);

   atx_state_e        state;
   atx_cfg_t          cur_cfg;
   logic [DATA_W-1:0] shreg;
   logic [BL_W-1:0]   bits_left;
   logic              par_q;
   logic              src_par;

   atx_parity #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .SEL_W(2)) u_parity (
      .data    (src_data),
      .len_sel (src_cfg.len_sel),
      .even    (src_cfg.par_even),
      .par_bit (src_par)
   );

   assign take = src_v && ((state == ST_IDLE) || (state == ST_STOP && bit_done));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_cfg   <= '0;
         shreg     <= '0;
         bits_left <= '0;
         par_q     <= 1'b0;
      end else if (take) begin
         state     <= ST_START;
         cur_cfg   <= src_cfg;
         shreg     <= src_data;
         par_q     <= src_par;
         bits_left <= BL_W'(MIN_BITS - 1) + BL_W'(src_cfg.len_sel);
      end else if (bit_done) begin
         case (state)
            ST_START:  state <= ST_DATA;
            ST_DATA: begin
               shreg <= shreg >> 1;
               if (bits_left == '0) begin
                  state <= cur_cfg.par_en ? ST_PARITY : ST_STOP;
               end else begin
                  bits_left <= bits_left - BL_W'(1);
               end
            end
            ST_PARITY: state <= ST_STOP;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_START:  line_o = 1'b0;
         ST_DATA:   line_o = shreg[0];
         ST_PARITY: line_o = par_q;
         default:   line_o = 1'b1;
      endcase
   end

   assign state_o   = state;
   assign cfg_o     = cur_cfg;
   assign run_o     = (state != ST_IDLE);
   assign in_stop_o = (state == ST_STOP);

   assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(cur_cfg));

   assert_line_paced_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_o != $past(line_o)) |-> ($past(bit_done) || $past(take)));

   assert_start_from_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && $past(state) != ST_START) |-> $past(line_o));

   assert_parity_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PARITY) |-> ($past(state) == ST_DATA || $past(state) == ST_PARITY));

endmodule

// File: rtl/async_char_tx.sv
`timescale 1ns/1ps
module async_char_tx
   import atx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MIN_BITS = 5,
   parameter int LOG_A    = 4,
   parameter int LOG_B    = 5,
   parameter int LOG_C    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              load_valid,
   output logic              load_ready,
   input  logic [DATA_W-1:0] load_data,
   input  logic [1:0]        cfg_len_sel,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   input  logic [1:0]        cfg_stop_sel,
   input  logic [1:0]        cfg_factor,
   output logic              tx_line
);

   localparam int CNT_W = LOG_C + 2;

   if (DATA_W != MIN_BITS + 3 || MIN_BITS < 1) begin : g_bad_width
      $error("async_char_tx: DATA_W must equal MIN_BITS + 3");
   end

   atx_cfg_t          cfg_in;
   atx_cfg_t          pend_cfg;
   atx_cfg_t          src_cfg;
   atx_cfg_t          cur_cfg;
   logic [DATA_W-1:0] pend_data;
   logic [DATA_W-1:0] src_data;
   logic              pend_v;
   logic              accept;
   logic              take;
   logic              bit_done;
   logic              run;
   logic              in_stop;
   atx_state_e        state;

   always_comb begin
      cfg_in.len_sel  = cfg_len_sel;
      cfg_in.par_en   = cfg_par_en;
      cfg_in.par_even = cfg_par_even;
      cfg_in.stop     = atx_stop_e'(cfg_stop_sel);
      cfg_in.factor   = atx_factor_e'(cfg_factor);
   end

   assign load_ready = ((state == ST_IDLE) || (state == ST_STOP)) && !pend_v
                       && (cfg_stop_sel != STOP_OFF);
   assign accept     = load_valid && load_ready;

   assign src_cfg  = pend_v ? pend_cfg  : cfg_in;
   assign src_data = pend_v ? pend_data : load_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_cfg  <= '0;
         pend_data <= '0;
      end else if (accept && !take) begin
         pend_v    <= 1'b1;
         pend_cfg  <= cfg_in;
         pend_data <= load_data;
      end else if (take) begin
         pend_v    <= 1'b0;
      end
   end

   atx_frame_ctrl #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_v     (pend_v || accept),
      .src_data  (src_data),
      .src_cfg   (src_cfg),
      .bit_done  (bit_done),
      .take      (take),
      .state_o   (state),
      .cfg_o     (cur_cfg),
      .run_o     (run),
      .in_stop_o (in_stop),
      .line_o    (tx_line)
   );

   atx_bit_timer #(.CNT_W(CNT_W), .LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en   (clk_en),
      .run      (run),
      .in_stop  (in_stop),
      .factor   (cur_cfg.factor),
      .stop_sel (cur_cfg.stop),
      .bit_done (bit_done)
   );

   assert_ready_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_ready |-> (state == ST_IDLE || state == ST_STOP));

   assert_waiting_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && !take) |=> (pend_v && $stable(pend_data) && $stable(pend_cfg)));

   assert_idle_without_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_stop_sel == STOP_OFF && state == ST_IDLE && !pend_v) |=> (state == ST_IDLE));

endmodule

// File: tb/async_char_tx_bench.sv
`timescale 1ns/1ps
module async_char_tx_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en = 1'b0;
   logic       load_valid = 1'b0;
   logic [7:0] load_data = 8'h00;
   logic [1:0] cfg_len_sel = 2'b11;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic [1:0] cfg_stop_sel = 2'b01;
   logic [1:0] cfg_factor = 2'b01;
   logic       load_ready;
   logic       tx_line;

   int  en_div = 1;
   int  n_vec = 0;
   int  n_bad = 0;
   bit  mon_busy = 1'b0;

   typedef struct {
      logic [7:0] data;
      int         len;
      bit         pe;
      bit         pev;
      int         stop;
      int         fac;
      bit         b2b;
      string      tag;
   } frame_t;

   frame_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   async_char_tx u_async_char_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .clk_en       (clk_en),
      .load_valid   (load_valid),
      .load_ready   (load_ready),
      .load_data    (load_data),
      .cfg_len_sel  (cfg_len_sel),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_even (cfg_par_even),
      .cfg_stop_sel (cfg_stop_sel),
      .cfg_factor   (cfg_factor),
      .tx_line      (tx_line)
   );

   initial begin : enable_gen
      int c;
      c = 0;
      forever begin
         @(posedge clk);
         #1;
         clk_en = ((c % en_div) == 0);
         c++;
      end
   end

   task automatic check(string req, int act, int exp, string what);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic get_sample(output logic s);
      do @(negedge clk); while (!clk_en);
      s = tx_line;
   endtask

   task automatic send(logic [7:0] d, int len, bit pe, bit pev, int stop, int fac,
                       bit b2b, string tag);
      frame_t f;
      @(posedge clk);
      #1;
      load_data    = d;
      cfg_len_sel  = 2'(len - 5);
      cfg_par_en   = pe;
      cfg_par_even = pev;
      cfg_stop_sel = 2'(stop);
      cfg_factor   = 2'(fac);
      load_valid   = 1'b1;
      do @(negedge clk); while (!load_ready);
      f.data = d; f.len = len; f.pe = pe; f.pev = pev;
      f.stop = stop; f.fac = fac; f.b2b = b2b; f.tag = tag;
      @(posedge clk);
      exp_q.push_back(f);
      #1;
      load_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || mon_busy) @(negedge clk);
      repeat (5) @(negedge clk);
   endtask

   // Scoreboard monitor: one sample per enable pulse, decoded into frames
   initial begin : monitor
      int     gap;
      logic   s;
      frame_t f;
      int     unit, nstop, segs, n, ones;
      bit     mism;
      int     bad_seg;
      logic   expv, gotv, badexp;
      gap = 0;
      @(posedge rst_n);
      forever begin
         get_sample(s);
         if (s === 1'b1) begin
            gap++;
         end else begin
            mon_busy = 1'b1;
            if (exp_q.size() == 0) begin
               n_vec++;
               n_bad++;
               $display("FAIL R7 unexpected start bit: actual 0 expected 1");
            end else begin
               f = exp_q.pop_front();
               if (f.b2b) check("R9", gap, 0, "mark samples between back-to-back frames");
               unit  = (f.fac == 0) ? 1 : (16 << (f.fac - 1));
               nstop = (f.stop == 1) ? unit : (f.stop == 3) ? 2 * unit
                     : ((unit == 1) ? 2 : unit + unit / 2);
               ones  = $countones(f.data & 8'((1 << f.len) - 1));
               segs  = 1 + f.len + (f.pe ? 1 : 0) + 1;
               mism  = 1'b0;
               bad_seg = 0; gotv = 1'b0; badexp = 1'b0;
               for (int b = 0; b < segs; b++) begin
                  n = unit;
                  if (b == 0) expv = 1'b0;
                  else if (b <= f.len) expv = f.data[b-1];
                  else if (f.pe && b == f.len + 1) expv = f.pev ? ones[0] : ~ones[0];
                  else begin expv = 1'b1; n = nstop; end
                  for (int k = 0; k < n; k++) begin
                     if (!(b == 0 && k == 0)) get_sample(s);
                     if (s !== expv && !mism) begin
                        mism = 1'b1; bad_seg = b; gotv = s; badexp = expv;
                     end
                  end
               end
               n_vec++;
               if (mism) begin
                  n_bad++;
                  $display("FAIL %s frame %02h segment %0d: actual %b expected %b",
                           f.tag, f.data, bad_seg, gotv, badexp);
               end
            end
            gap = 0;
            mon_busy = 1'b0;
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      repeat (5) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(tx_line), 1, "line after reset");
      check("R10", int'(load_ready), 1, "ready after reset");

      // R1 R2 R5 R10: 8 data bits, x16, no parity, one stop; ready phases per R9
      en_div = 1;
      send(8'hA5, 8, 0, 0, 1, 1, 0, "R2");
      repeat (10) @(negedge clk);
      check("R9", int'(load_ready), 0, "ready during start bit");
      repeat (142) @(negedge clk);
      check("R9", int'(load_ready), 1, "ready during stop period");
      drain();

      // R2 R3: 5 bits with upper bits set, odd parity, x1
      en_div = 2;
      send(8'hF3, 5, 1, 0, 1, 0, 0, "R3");
      drain();
      // R3 R4: 7 bits even parity x32 two stop bits
      en_div = 1;
      send(8'h6B, 7, 1, 1, 3, 2, 0, "R4");
      drain();
      // R4 R5: 6 bits x64 one-and-a-half stop bits
      send(8'hD2, 6, 0, 0, 2, 3, 0, "R5");
      drain();
      // R6: x1 with one-and-a-half selected gives two stop bits
      en_div = 3;
      send(8'h3C, 8, 1, 0, 2, 0, 0, "R6");
      drain();

      // R9: back-to-back at x1, enable every cycle, then every third
      en_div = 1;
      send(8'h81, 8, 0, 0, 1, 0, 0, "R9");
      send(8'h7E, 8, 1, 1, 1, 0, 1, "R9");
      send(8'h15, 5, 0, 0, 1, 0, 1, "R9");
      drain();
      en_div = 3;
      send(8'hC3, 8, 0, 0, 1, 0, 0, "R9");
      send(8'h5A, 6, 1, 0, 3, 1, 1, "R9");
      drain();

      // R8: framing inputs changed right after load
      en_div = 1;
      send(8'h2D, 6, 1, 1, 1, 1, 0, "R8");
      cfg_len_sel = 2'b11; cfg_par_en = 1'b0; cfg_par_even = 1'b0;
      cfg_stop_sel = 2'b11; cfg_factor = 2'b00; load_data = 8'hFF;
      drain();

      // R7: disabled stop setting blocks loads and keeps mark
      @(posedge clk);
      #1;
      cfg_stop_sel = 2'b00;
      load_valid   = 1'b1;
      load_data    = 8'h00;
      begin
         int seen_ready, seen_space;
         seen_ready = 0; seen_space = 0;
         repeat (40) begin
            @(negedge clk);
            if (load_ready) seen_ready++;
            if (!tx_line) seen_space++;
         end
         check("R7", seen_ready, 0, "ready cycles while stop disabled");
         check("R7", seen_space, 0, "space cycles while stop disabled");
      end
      @(posedge clk);
      #1;
      load_valid   = 1'b0;
      cfg_stop_sel = 2'b01;
      @(negedge clk);
      check("R7", int'(load_ready), 1, "ready once stop re-enabled");
      check("R1", int'(tx_line), 1, "line idle after disabled period");

      drain();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule